// File: doc/BRIEF.md
# Presettable Down Counter with Zero Flag

This block is a synchronous down counter that can be loaded with a start value and that signals when its count reaches zero. A parameter selects one of two number systems at build time. In decimal mode the counter holds two BCD digits and covers 0 to 99. In binary mode it holds an 8-bit value and covers 0 to 255. Each rising clock edge takes one off the count, and counting down from zero wraps to the top of the range. A typical use is as a programmable divider or delay: load N, then wait for the flag.

Four active-low controls act on the counter in a fixed order of precedence. The clear control forces the full-scale value. The immediate load control makes the start value visible at once, without waiting for an edge. The edge load control takes the start value on the next rising edge. The hold control freezes the count and masks the flag. Because the flag is masked by the hold input, several counters can be chained by driving one stage's hold input from the previous stage's flag.

Top module: `preset_down_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count is set to full scale (99 decimal / 255 binary) and `zero_n` reads 1.
- R2: With all four controls high, each rising edge lowers the count by exactly one. `zero_n` is 0 whenever the visible count is zero and `hold_n` is high, and 1 otherwise.
- R3: In decimal mode, `load_val[7:4]` is the tens digit and `load_val[3:0]` is the units digit, each in the range 0 to 9. The units digit counts 9 down to 0 and borrows one from the tens digit, so a load of N reaches zero after N edges.
- R4: In binary mode, `load_val` is an unsigned 8-bit number, and a load of N reaches zero after N edges for any N up to 255.
- R5: If the count is zero and no control is active, the next edge sets the count to full scale (99 or 255).
- R6: While `clr_n` is low, the visible count is full scale at once, with no edge needed, and the stored count is full scale after each edge.
- R7: While `apre_n` is low, the visible count equals `load_val` at once, and each edge stores `load_val`. After `apre_n` rises, counting continues from the stored value.
- R8: A low `spre_n` changes nothing before the next rising edge. At that edge the count takes `load_val`.
- R9: While `hold_n` is low, edges leave the count unchanged and `zero_n` is held at 1.
- R10: Precedence from highest to lowest is `clr_n`, `apre_n`, `spre_n`, `hold_n`, then counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset to full scale |
| load_val | input | WIDTH (8) | Start value; two BCD digits in decimal mode |
| clr_n | input | 1 | Active-low clear to full scale, immediate |
| apre_n | input | 1 | Active-low immediate load of `load_val` |
| spre_n | input | 1 | Active-low load of `load_val` at the next edge |
| hold_n | input | 1 | Active-low count hold; also masks the flag |
| zero_n | output | 1 | Active-low zero flag |

## Verification
Results are due at two different times. The effects of clear, immediate load and hold reach `zero_n` within the same cycle, so the bench checks the flag 1 ns after it changes those inputs, with no clock edge in between. Edge load, counting and wrap take effect one edge later, so the bench moves its reference counts at the rising edge and compares at the following falling edge. A decimal instance and a binary instance share every input, which makes the borrow between digits and the 0-to-255 wrap observable side by side.

// File: rtl/pdc_pkg.sv
// pdc_pkg: shared types and the full-scale function for the preset down counter.
// Assumes WIDTH is a multiple of 4 in decimal mode and at most 63.
package pdc_pkg;

    // number system selected at build time
    typedef enum logic {
        MODE_BIN = 1'b0,
        MODE_BCD = 1'b1
    } pdc_mode_e;

    // source of the value stored at the next edge
    typedef enum logic [1:0] {
        NXT_MAX,
        NXT_LOAD,
        NXT_HOLD,
        NXT_DEC
    } pdc_next_e;

    // source of the value seen by the flag in the current cycle
    typedef enum logic [1:0] {
        VIEW_MAX,
        VIEW_LOAD,
        VIEW_REG
    } pdc_view_e;

    // full-scale code: all ones in binary, all nines per digit in decimal
    function automatic longint unsigned pdc_max_code(int unsigned width, pdc_mode_e mode);
        longint unsigned v;
        v = 0;
        if (mode == MODE_BIN) begin
            v = (64'd1 << width) - 64'd1;
        end else begin
            for (int i = 0; i < int'(width / 4); i++) begin
                v = (v << 4) | 64'd9;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/pdc_bcd_digit.sv
// pdc_bcd_digit: one decimal digit of the down counter.
// Takes one off the digit when a borrow comes in, and passes a borrow on
// when the digit was zero. Assumes the input digit is in 0..9.
module pdc_bcd_digit (
    input  logic [3:0] digit_in,
    input  logic       borrow_in,
    output logic [3:0] digit_out,
    output logic       borrow_out
);

    logic digit_zero;

    // digit at its lowest value
    assign digit_zero = (digit_in == 4'd0);

    // decrement with wrap from 0 to 9 when a borrow arrives
    always_comb begin : digit_step
        if (!borrow_in) begin
            digit_out = digit_in;
        end else if (digit_zero) begin
            digit_out = 4'd9;
        end else begin
            digit_out = digit_in - 4'd1;
        end
    end

    // borrow passes upward only through a zero digit
    assign borrow_out = borrow_in & digit_zero;

endmodule

// File: rtl/pdc_decrement.sv
// pdc_decrement: the count-minus-one value and the "all zero" indication.
// In decimal mode this is a chain of digit cells, and the borrow out of the
// top digit means the whole value is zero. In binary mode it is a plain
// subtraction with a zero compare. Both modes wrap from zero to full scale.
module pdc_decrement
    import pdc_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter pdc_mode_e   MODE  = MODE_BCD
) (
    input  logic [WIDTH-1:0] cur_val,
    output logic [WIDTH-1:0] dec_val,
    output logic             is_zero
);

    localparam int unsigned DIGITS = WIDTH / 4;

    generate
        if (MODE == MODE_BIN) begin : g_bin
            // binary decrement; wrap to all ones comes from modular arithmetic
            assign dec_val = cur_val - {{(WIDTH-1){1'b0}}, 1'b1};
            assign is_zero = (cur_val == '0);
        end else begin : g_bcd
            logic [DIGITS-1:0] borrow;

            for (genvar d = 0; d < DIGITS; d++) begin : g_digit
                logic digit_borrow_in;

                // units digit always receives the borrow of the decrement
                if (d == 0) begin : g_first
                    assign digit_borrow_in = 1'b1;
                end else begin : g_next
                    assign digit_borrow_in = borrow[d-1];
                end

                pdc_bcd_digit u_digit (
                    .digit_in   (cur_val[4*d +: 4]),
                    .borrow_in  (digit_borrow_in),
                    .digit_out  (dec_val[4*d +: 4]),
                    .borrow_out (borrow[d])
                );
            end

            // a borrow out of the top digit means every digit was zero
            assign is_zero = borrow[DIGITS-1];
        end
    endgenerate

endmodule

// File: rtl/pdc_ctrl.sv
// pdc_ctrl: resolves the four active-low controls into two selections, one for
// the next stored value and one for the value seen in the current cycle.
// Precedence: clear, immediate load, edge load, hold, count.
module pdc_ctrl
    import pdc_pkg::*;
(
    input  logic      clr_n,
    input  logic      apre_n,
    input  logic      spre_n,
    input  logic      hold_n,
    output pdc_next_e next_sel,
    output pdc_view_e view_sel
);

    // choose what the register takes at the coming edge
    always_comb begin : pick_next
        if (!clr_n) begin
            next_sel = NXT_MAX;
        end else if (!apre_n) begin
            next_sel = NXT_LOAD;
        end else if (!spre_n) begin
            next_sel = NXT_LOAD;
        end else if (!hold_n) begin
            next_sel = NXT_HOLD;
        end else begin
            next_sel = NXT_DEC;
        end
    end

    // choose what the flag sees now; only the immediate controls bypass the register
    always_comb begin : pick_view
        if (!clr_n) begin
            view_sel = VIEW_MAX;
        end else if (!apre_n) begin
            view_sel = VIEW_LOAD;
        end else begin
            view_sel = VIEW_REG;
        end
    end

endmodule

// File: rtl/preset_down_counter.sv
// preset_down_counter: presettable down counter with an active-low zero flag.
// The immediate clear and immediate load act through a bypass mux in front of
// the count register, so they reach the flag in the same cycle and are
// captured at each edge while held. Reset is synchronous and active low and
// sets full scale. Assumes decimal-mode presets carry digits in 0..9.
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter pdc_mode_e   MODE  = MODE_BCD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] load_val,
    input  logic             clr_n,
    input  logic             apre_n,
    input  logic             spre_n,
    input  logic             hold_n,
    output logic             zero_n
);

    localparam logic [WIDTH-1:0] MAX_CODE = WIDTH'(pdc_max_code(WIDTH, MODE));

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] view_val;
    logic [WIDTH-1:0] dec_val;
    logic             view_zero;
    pdc_next_e        next_sel;
    pdc_view_e        view_sel;

    pdc_ctrl u_ctrl (
        .clr_n    (clr_n),
        .apre_n   (apre_n),
        .spre_n   (spre_n),
        .hold_n   (hold_n),
        .next_sel (next_sel),
        .view_sel (view_sel)
    );

    // value visible this cycle: bypasses the register for clear and immediate load
    always_comb begin : view_mux
        case (view_sel)
            VIEW_MAX:  view_val = MAX_CODE;
            VIEW_LOAD: view_val = load_val;
            default:   view_val = count_q;
        endcase
    end

    // decrement and zero detect share one borrow chain on the visible value
    pdc_decrement #(
        .WIDTH (WIDTH),
        .MODE  (MODE)
    ) u_dec (
        .cur_val (view_val),
        .dec_val (dec_val),
        .is_zero (view_zero)
    );

    // count register with synchronous reset to full scale
    always_ff @(posedge clk) begin : count_reg
        if (!rst_n) begin
            count_q <= MAX_CODE;
        end else begin
            case (next_sel)
                NXT_MAX:  count_q <= MAX_CODE;
                NXT_LOAD: count_q <= load_val;
                NXT_HOLD: count_q <= count_q;
                default:  count_q <= dec_val;
            endcase
        end
    end

    // active-low flag, masked by hold so a chained stage only counts on it
    assign zero_n = ~(view_zero & hold_n);

endmodule

// File: rtl/pdc_checker.sv
// pdc_checker: properties of the preset down counter, attached by bind.
// Observes the ports and the stored count; drives nothing.
module pdc_checker
    import pdc_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter pdc_mode_e   MODE  = MODE_BCD
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] load_val,
    input logic             clr_n,
    input logic             apre_n,
    input logic             spre_n,
    input logic             hold_n,
    input logic [WIDTH-1:0] count_q,
    input logic             zero_n
);

    localparam logic [WIDTH-1:0] MAX_CODE = WIDTH'(pdc_max_code(WIDTH, MODE));

    // flag goes active on a stored zero when nothing overrides it
    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && clr_n && apre_n && hold_n) |-> !zero_n);

    // counting from zero wraps to full scale
    assert_wrap_to_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && clr_n && apre_n && spre_n && hold_n) |=> (count_q == MAX_CODE));

    // clear keeps the flag inactive at once and stores full scale
    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> zero_n);
    assert_clear_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (count_q == MAX_CODE));

    // immediate load of zero shows on the flag without an edge
    assert_load_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !apre_n && load_val == '0 && hold_n) |-> !zero_n);

    // edge load stores the start value, even while hold is low (R10)
    assert_edge_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && apre_n && !spre_n) |=> (count_q == $past(load_val)));

    // hold freezes the count and masks the flag
    assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && apre_n && spre_n && !hold_n) |=> $stable(count_q));
    assert_hold_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> zero_n);

endmodule

bind preset_down_counter pdc_checker #(
    .WIDTH (WIDTH),
    .MODE  (MODE)
) u_pdc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_val (load_val),
    .clr_n    (clr_n),
    .apre_n   (apre_n),
    .spre_n   (spre_n),
    .hold_n   (hold_n),
    .count_q  (count_q),
    .zero_n   (zero_n)
);

// File: tb/preset_down_counter_bench.sv
// preset_down_counter_bench: drives a decimal and a binary counter from the
// same inputs and compares both flags with integer reference counts.
module preset_down_counter_bench;
    import pdc_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n    = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic       clr_n    = 1'b1;
    logic       apre_n   = 1'b1;
    logic       spre_n   = 1'b1;
    logic       hold_n   = 1'b1;
    logic       zero_n_bcd;
    logic       zero_n_bin;

    int checks   = 0;
    int failures = 0;
    int ref_bcd  = 99;
    int ref_bin  = 255;
    bit done     = 1'b0;

    preset_down_counter #(.WIDTH(8), .MODE(MODE_BCD)) u_preset_down_counter (
        .clk (clk), .rst_n (rst_n), .load_val (load_val), .clr_n (clr_n),
        .apre_n (apre_n), .spre_n (spre_n), .hold_n (hold_n), .zero_n (zero_n_bcd)
    );

    preset_down_counter #(.WIDTH(8), .MODE(MODE_BIN)) u_preset_down_counter_bin (
        .clk (clk), .rst_n (rst_n), .load_val (load_val), .clr_n (clr_n),
        .apre_n (apre_n), .spre_n (spre_n), .hold_n (hold_n), .zero_n (zero_n_bin)
    );

    function automatic int dec_of(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    // reference counts step at the rising edge, following the precedence rules
    task automatic model_edge();
        if (!rst_n || !clr_n) begin
            ref_bcd = 99;
            ref_bin = 255;
        end else if (!apre_n || !spre_n) begin
            ref_bcd = dec_of(load_val);
            ref_bin = int'(load_val);
        end else if (hold_n) begin
            ref_bcd = (ref_bcd == 0) ? 99 : ref_bcd - 1;
            ref_bin = (ref_bin == 0) ? 255 : ref_bin - 1;
        end
    endtask

    // compare both flags with the reference view of the current cycle
    task automatic check(string tag);
        int   vb;
        int   vn;
        logic eb;
        logic en;
        vb = !clr_n ? 99  : (!apre_n ? dec_of(load_val) : ref_bcd);
        vn = !clr_n ? 255 : (!apre_n ? int'(load_val)   : ref_bin);
        eb = !((vb == 0) && (hold_n == 1'b1));
        en = !((vn == 0) && (hold_n == 1'b1));
        checks += 2;
        if (zero_n_bcd !== eb) begin
            failures++;
            $display("FAIL %s decimal zero_n actual=%0b expected=%0b (ref=%0d)", tag, zero_n_bcd, eb, vb);
        end
        if (zero_n_bin !== en) begin
            failures++;
            $display("FAIL %s binary zero_n actual=%0b expected=%0b (ref=%0d)", tag, zero_n_bin, en, vn);
        end
    endtask

    task automatic cycle(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        // R1: reset sets full scale
        repeat (2) cycle("R1");
        rst_n = 1'b1;
        repeat (3) cycle("R2");

        // R8: edge load shows nothing before the edge
        load_val = 8'h03;
        spre_n   = 1'b0;
        #1 check("R8");
        cycle("R8");
        spre_n = 1'b1;
        repeat (3) cycle("R2");
        cycle("R5");

        // R3: tens borrow; binary counts the same code as 16
        load_val = 8'h10;
        spre_n   = 1'b0;
        cycle("R3");
        spre_n = 1'b1;
        repeat (18) cycle("R3");

        // R4: large values in both systems
        load_val = 8'h99;
        spre_n   = 1'b0;
        cycle("R4");
        spre_n = 1'b1;
        repeat (160) cycle("R4");
        repeat (260) cycle("R5");

        // R7: immediate load of zero
        load_val = 8'h00;
        apre_n   = 1'b0;
        #1 check("R7");
        repeat (2) cycle("R7");
        apre_n = 1'b1;
        #1 check("R7");

        // R9: hold masks the flag and freezes the count
        hold_n = 1'b0;
        #1 check("R9");
        repeat (3) cycle("R9");
        hold_n = 1'b1;
        #1 check("R9");
        cycle("R5");

        // R6 and R10: clear beats immediate load at once
        apre_n = 1'b0;
        #1 check("R7");
        clr_n = 1'b0;
        #1 check("R6");
        cycle("R10");
        apre_n = 1'b1;
        cycle("R6");
        clr_n = 1'b1;
        #1 check("R6");
        repeat (2) cycle("R2");

        // R10: edge load beats hold
        load_val = 8'h02;
        spre_n   = 1'b0;
        hold_n   = 1'b0;
        cycle("R10");
        spre_n = 1'b1;
        hold_n = 1'b1;
        repeat (3) cycle("R10");

        // R10: mixed controls, checked both just after the change and after the edge
        for (int i = 0; i < 3000; i++) begin
            load_val = {4'($urandom % 10), 4'($urandom % 10)};
            clr_n    = ($urandom % 16) != 0;
            apre_n   = ($urandom % 12) != 0;
            spre_n   = ($urandom % 8) != 0;
            hold_n   = ($urandom % 6) != 0;
            #1 check("R10");
            cycle("R10");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule